// File: doc/BRIEF.md
# Rotating Windowed Register File

A physical store of 64 registers, each 32 bits wide. Logic around it sees only 16 of them at a time. A window-base register points at the start of the visible window in steps of four registers. A logical register number is turned into a physical one by adding the base times four. The sum wraps modulo the physical count, so a window that runs past the top continues at physical register 0.

Two combinational read ports and one clocked write port all use 4-bit logical numbers. The window moves in one of two ways: by a signed relative step, or by loading an absolute new base. Either way the move takes effect at the next clock edge and copies no data; only the mapping changes. A separate window-start register keeps one flag per four-register group and can be loaded as a whole.

Top module: `winreg_file`

## Requirements
- R1: After reset, `win_base` is 0 and `win_start` is 16'h0001.
- R2: Each read port returns the physical register at index (win_base*4 + logical index) mod 64, combinationally through the current base.
- R3: A window whose logical indices pass physical register 63 continues at physical register 0 (e.g. base 15, logical 4 reads physical 0).
- R4: With `rot_rel_en` high, the next base is (win_base + sign-extended 4-bit `rot_delta`) mod 16, so steps from -8 to +7 are possible. With no rotate command the base holds.
- R5: With `base_wr_en` high, the next base is bits [3:0] of `base_wr_val`; bits [7:4] are ignored.
- R6: When `base_wr_en` and `rot_rel_en` are both high, the absolute load wins.
- R7: A write issued in the same cycle as a rotate lands at the physical register chosen by the base from before the rotate.
- R8: A read of a register being written in the same cycle returns the old value; the new value is visible after the clock edge.
- R9: `start_wr_en` replaces all 16 bits of `win_start` and leaves the base unchanged; moving the base leaves `win_start` unchanged.
- R10: With `wr_en` low, `wr_data` and `wr_idx` change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_a_idx | input | 4 | Logical register number, read port A |
| rd_a_data | output | 32 | Read data, port A |
| rd_b_idx | input | 4 | Logical register number, read port B |
| rd_b_data | output | 32 | Read data, port B |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 4 | Logical register number for the write |
| wr_data | input | 32 | Write data |
| rot_rel_en | input | 1 | Relative rotate command |
| rot_delta | input | 4 | Signed rotate step, in groups of four |
| base_wr_en | input | 1 | Absolute base load command |
| base_wr_val | input | 8 | New base; only the low 4 bits are used |
| start_wr_en | input | 1 | Load the window-start register |
| start_wr_val | input | 16 | New window-start value |
| win_base | output | 4 | Current window base |
| win_start | output | 16 | Current window-start flags |

## Verification
The hardest case to reach is a window that straddles the top of the physical store, because a value is only recognisable there if every physical register holds a known, distinct value. The bench therefore first loads each physical register with a value that encodes its own index, moving the window across all sixteen groups and writing four registers in each. It then walks signed and absolute rotations, including steps of -8, +7 and bases that wrap, and reads both ports at each stop. A write combined with a backward rotate in the same cycle is then identified by reading the written value back under the new window at its shifted logical index.

// File: rtl/winreg_pkg.sv
package winreg_pkg;

    typedef enum logic [1:0] {
        ROT_HOLD = 2'd0,
        ROT_REL  = 2'd1,
        ROT_ABS  = 2'd2
    } rot_kind_e;

    function automatic rot_kind_e pick_rot(input logic rel_en, input logic abs_en);
        if (abs_en) begin
            return ROT_ABS;
        end else if (rel_en) begin
            return ROT_REL;
        end
        return ROT_HOLD;
    endfunction

endpackage

// File: rtl/winreg_map.sv
module winreg_map #(
    parameter int LOG_W  = 4,
    parameter int WB_W   = 4,
    parameter int GSH    = 2,
    parameter int PHYS_W = 6
) (
    input  logic [WB_W-1:0]   base,
    input  logic [LOG_W-1:0]  log_idx,
    output logic [PHYS_W-1:0] phys_idx
);
    localparam int SUM_W = (WB_W + GSH > LOG_W) ? WB_W + GSH + 1 : LOG_W + 1;

    logic [SUM_W-1:0] offset;
    logic [SUM_W-1:0] sum;

    always_comb begin
        offset   = SUM_W'({base, {GSH{1'b0}}});
        sum      = offset + SUM_W'(log_idx);
        phys_idx = sum[PHYS_W-1:0];
    end

endmodule

// File: rtl/winreg_ctrl.sv
module winreg_ctrl
    import winreg_pkg::*;
#(
    parameter int WB_W      = 4,
    parameter int NGROUPS   = 16,
    parameter int DELTA_W   = 4,
    parameter int BASE_IN_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rot_rel_en,
    input  logic [DELTA_W-1:0]   rot_delta,
    input  logic                 base_wr_en,
    input  logic [BASE_IN_W-1:0] base_wr_val,
    input  logic                 start_wr_en,
    input  logic [NGROUPS-1:0]   start_wr_val,
    output logic [WB_W-1:0]      base_q_o,
    output logic [NGROUPS-1:0]   start_q_o
);
    typedef struct packed {
        logic [WB_W-1:0]    base;
        logic [NGROUPS-1:0] start;
    } ctrl_t;

    ctrl_t st_d, st_q;
    rot_kind_e kind;
    logic [WB_W+DELTA_W-1:0] delta_wide;
    logic [WB_W-1:0]         delta_ext;

    always_comb begin
        delta_wide = {{WB_W{rot_delta[DELTA_W-1]}}, rot_delta};
        delta_ext  = delta_wide[WB_W-1:0];
        kind       = pick_rot(rot_rel_en, base_wr_en);
        st_d       = st_q;
        case (kind)
            ROT_REL: st_d.base = st_q.base + delta_ext;
            ROT_ABS: st_d.base = base_wr_val[WB_W-1:0];
            default: st_d.base = st_q.base;
        endcase
        if (start_wr_en) begin
            st_d.start = start_wr_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.base  <= '0;
            st_q.start <= NGROUPS'(1);
        end else begin
            st_q <= st_d;
        end
    end

    assign base_q_o  = st_q.base;
    assign start_q_o = st_q.start;

endmodule

// File: rtl/winreg_bank.sv
module winreg_bank #(
    parameter int DATA_W  = 32,
    parameter int ENTRIES = 64,
    parameter int IDX_W   = 6,
    parameter int NRD     = 2
) (
    input  logic              clk,
    input  logic [IDX_W-1:0]  rd_idx  [NRD],
    output logic [DATA_W-1:0] rd_data [NRD],
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data
);
    logic [DATA_W-1:0] mem_d [ENTRIES];
    logic [DATA_W-1:0] mem_q [ENTRIES];

    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            mem_d[i] = mem_q[i];
        end
        if (wr_en) begin
            mem_d[wr_idx] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < ENTRIES; i++) begin
            mem_q[i] <= mem_d[i];
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rd_data[p] = mem_q[rd_idx[p]];
    end

endmodule

// File: rtl/winreg_file.sv
module winreg_file #(
    parameter int DATA_W    = 32,
    parameter int PHYS_REGS = 64,
    parameter int WIN_REGS  = 16,
    parameter int GROUP     = 4,
    parameter int DELTA_W   = 4,
    parameter int BASE_IN_W = 8,
    localparam int LOG_W    = $clog2(WIN_REGS),
    localparam int PHYS_W   = $clog2(PHYS_REGS),
    localparam int NGROUPS  = PHYS_REGS / GROUP,
    localparam int WB_W     = $clog2(NGROUPS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [LOG_W-1:0]     rd_a_idx,
    output logic [DATA_W-1:0]    rd_a_data,
    input  logic [LOG_W-1:0]     rd_b_idx,
    output logic [DATA_W-1:0]    rd_b_data,
    input  logic                 wr_en,
    input  logic [LOG_W-1:0]     wr_idx,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic                 rot_rel_en,
    input  logic [DELTA_W-1:0]   rot_delta,
    input  logic                 base_wr_en,
    input  logic [BASE_IN_W-1:0] base_wr_val,
    input  logic                 start_wr_en,
    input  logic [NGROUPS-1:0]   start_wr_val,
    output logic [WB_W-1:0]      win_base,
    output logic [NGROUPS-1:0]   win_start
);
    localparam int GSH    = $clog2(GROUP);
    localparam int NRD    = 2;
    localparam int NMAP   = NRD + 1;
    localparam int WR_MAP = NRD;

    logic [WB_W-1:0]   base_cur;
    logic [LOG_W-1:0]  map_log  [NMAP];
    logic [PHYS_W-1:0] map_phys [NMAP];
    logic [PHYS_W-1:0] rd_phys  [NRD];
    logic [DATA_W-1:0] rd_word  [NRD];

    winreg_ctrl #(
        .WB_W     (WB_W),
        .NGROUPS  (NGROUPS),
        .DELTA_W  (DELTA_W),
        .BASE_IN_W(BASE_IN_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .rot_rel_en  (rot_rel_en),
        .rot_delta   (rot_delta),
        .base_wr_en  (base_wr_en),
        .base_wr_val (base_wr_val),
        .start_wr_en (start_wr_en),
        .start_wr_val(start_wr_val),
        .base_q_o    (base_cur),
        .start_q_o   (win_start)
    );

    assign map_log[0]      = rd_a_idx;
    assign map_log[1]      = rd_b_idx;
    assign map_log[WR_MAP] = wr_idx;

    for (genvar m = 0; m < NMAP; m++) begin : g_map
        winreg_map #(
            .LOG_W (LOG_W),
            .WB_W  (WB_W),
            .GSH   (GSH),
            .PHYS_W(PHYS_W)
        ) u_map (
            .base    (base_cur),
            .log_idx (map_log[m]),
            .phys_idx(map_phys[m])
        );
    end

    for (genvar r = 0; r < NRD; r++) begin : g_rdsel
        assign rd_phys[r] = map_phys[r];
    end

    winreg_bank #(
        .DATA_W (DATA_W),
        .ENTRIES(PHYS_REGS),
        .IDX_W  (PHYS_W),
        .NRD    (NRD)
    ) u_bank (
        .clk    (clk),
        .rd_idx (rd_phys),
        .rd_data(rd_word),
        .wr_en  (wr_en),
        .wr_idx (map_phys[WR_MAP]),
        .wr_data(wr_data)
    );

    assign rd_a_data = rd_word[0];
    assign rd_b_data = rd_word[1];
    assign win_base  = base_cur;

endmodule

// File: rtl/winreg_file_chk.sv
module winreg_file_chk #(
    parameter int WB_W      = 4,
    parameter int NGROUPS   = 16,
    parameter int DELTA_W   = 4,
    parameter int BASE_IN_W = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 rot_rel_en,
    input logic [DELTA_W-1:0]   rot_delta,
    input logic                 base_wr_en,
    input logic [BASE_IN_W-1:0] base_wr_val,
    input logic                 start_wr_en,
    input logic [NGROUPS-1:0]   start_wr_val,
    input logic [WB_W-1:0]      win_base,
    input logic [NGROUPS-1:0]   win_start
);
    logic [WB_W+DELTA_W-1:0] dwide;
    assign dwide = {{WB_W{rot_delta[DELTA_W-1]}}, rot_delta};

    assert_reset_state_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (win_base == '0 && win_start == NGROUPS'(1)));

    assert_rel_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rot_rel_en && !base_wr_en) |=>
            win_base == WB_W'($past(win_base) + $past(dwide[WB_W-1:0])));

    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!rot_rel_en && !base_wr_en) |=> $stable(win_base));

    assert_abs_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        base_wr_en |=> win_base == $past(base_wr_val[WB_W-1:0]));

    assert_abs_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (base_wr_en && rot_rel_en) |=> win_base == $past(base_wr_val[WB_W-1:0]));

    assert_start_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start_wr_en |=> win_start == $past(start_wr_val));

    assert_start_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !start_wr_en |=> $stable(win_start));

endmodule

bind winreg_file winreg_file_chk #(
    .WB_W     (WB_W),
    .NGROUPS  (NGROUPS),
    .DELTA_W  (DELTA_W),
    .BASE_IN_W(BASE_IN_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rot_rel_en  (rot_rel_en),
    .rot_delta   (rot_delta),
    .base_wr_en  (base_wr_en),
    .base_wr_val (base_wr_val),
    .start_wr_en (start_wr_en),
    .start_wr_val(start_wr_val),
    .win_base    (win_base),
    .win_start   (win_start)
);

// File: tb/winreg_file_tb.sv
`timescale 1ns/1ps
module winreg_file_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0, rot_delta = '0;
    logic [31:0] rd_a_data, rd_b_data, wr_data = '0;
    logic        wr_en = 1'b0, rot_rel_en = 1'b0, base_wr_en = 1'b0, start_wr_en = 1'b0;
    logic [7:0]  base_wr_val = '0;
    logic [15:0] start_wr_val = '0;
    logic [3:0]  win_base;
    logic [15:0] win_start;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    winreg_file u_dut (
        .clk(clk), .rst_n(rst_n),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .rot_rel_en(rot_rel_en), .rot_delta(rot_delta),
        .base_wr_en(base_wr_en), .base_wr_val(base_wr_val),
        .start_wr_en(start_wr_en), .start_wr_val(start_wr_val),
        .win_base(win_base), .win_start(win_start)
    );

    // fields: [23:20] expected base, [16] absolute, [15:8] value, [7:4] port A, [3:0] port B
    localparam logic [23:0] VEC [10] = '{
        24'h10010F, 24'h80073C, 24'h000859, 24'hF10F04, 24'h31F3F1,
        24'h200F78, 24'hF00DFE, 24'h10022B, 24'h01106D, 24'h000013
    };

    function automatic logic [31:0] pattern(input int base, input int lidx);
        return 32'hA500_0000 | 32'((base * 4 + lidx) % 64);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        wr_en = 1'b0; rot_rel_en = 1'b0; base_wr_en = 1'b0; start_wr_en = 1'b0;
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        tick(); tick();
        rst_n = 1'b1;
        #1;
        chk("R1 base", 32'(win_base), 32'h0);
        chk("R1 start", 32'(win_start), 32'h0001);

        // load every physical register with its own index
        for (int g = 0; g < 16; g++) begin
            base_wr_en = 1'b1; base_wr_val = 8'(g);
            tick();
            idle();
            for (int l = 0; l < 4; l++) begin
                wr_en = 1'b1; wr_idx = 4'(l); wr_data = pattern(g, l);
                tick();
            end
            idle();
        end
        base_wr_en = 1'b1; base_wr_val = 8'h00;
        tick();
        idle();

        // R2 R3 R4 R5: rotation table
        for (int v = 0; v < 10; v++) begin
            int eb;
            eb = int'(VEC[v][23:20]);
            if (VEC[v][16]) begin
                base_wr_en = 1'b1; base_wr_val = VEC[v][15:8];
            end else begin
                rot_rel_en = 1'b1; rot_delta = VEC[v][11:8];
            end
            rd_a_idx = VEC[v][7:4];
            rd_b_idx = VEC[v][3:0];
            tick();
            idle();
            chk(VEC[v][16] ? "R5 base" : "R4 base", 32'(win_base), 32'(eb));
            chk("R2 R3 port A", rd_a_data, pattern(eb, int'(VEC[v][7:4])));
            chk("R2 R3 port B", rd_b_data, pattern(eb, int'(VEC[v][3:0])));
        end

        // R3: explicit wrap at base 15, logical 4 -> physical 0
        base_wr_en = 1'b1; base_wr_val = 8'h0F;
        tick();
        idle();
        rd_a_idx = 4'd4;
        #1;
        chk("R3 wrap", rd_a_data, 32'hA500_0000);
        base_wr_en = 1'b1; base_wr_val = 8'h00;
        tick();
        idle();

        // R10: disabled write changes nothing
        wr_en = 1'b0; wr_idx = 4'd2; wr_data = 32'hDEAD_BEEF;
        tick();
        rd_a_idx = 4'd2;
        #1;
        chk("R10 no write", rd_a_data, pattern(0, 2));

        // R8: read during write returns old value
        wr_en = 1'b1; wr_idx = 4'd5; wr_data = 32'h1234_5678;
        rd_a_idx = 4'd5;
        #1;
        chk("R8 old value", rd_a_data, pattern(0, 5));
        tick();
        idle();
        chk("R8 new value", rd_a_data, 32'h1234_5678);

        // R7: write with rotate by -1 lands at physical 2 (old base 0)
        wr_en = 1'b1; wr_idx = 4'd2; wr_data = 32'hCAFE_0002;
        rot_rel_en = 1'b1; rot_delta = 4'hF;
        tick();
        idle();
        rd_a_idx = 4'd6; rd_b_idx = 4'd2;
        #1;
        chk("R7 base", 32'(win_base), 32'd15);
        chk("R7 old slot", rd_a_data, 32'hCAFE_0002);
        chk("R7 new slot", rd_b_data, pattern(15, 2));

        // R6: absolute load beats relative step
        rot_rel_en = 1'b1; rot_delta = 4'd3;
        base_wr_en = 1'b1; base_wr_val = 8'h09;
        tick();
        idle();
        chk("R6 abs wins", 32'(win_base), 32'd9);

        // R9: start register load and independence
        start_wr_en = 1'b1; start_wr_val = 16'hA5C3;
        tick();
        idle();
        chk("R9 start", 32'(win_start), 32'hA5C3);
        chk("R9 base kept", 32'(win_base), 32'd9);
        rot_rel_en = 1'b1; rot_delta = 4'd2;
        tick();
        idle();
        chk("R9 start kept", 32'(win_start), 32'hA5C3);
        chk("R4 step", 32'(win_base), 32'd11);

        // R1: reset again
        rst_n = 1'b0;
        tick();
        rst_n = 1'b1;
        #1;
        chk("R1 re-reset base", 32'(win_base), 32'h0);
        chk("R1 re-reset start", 32'(win_start), 32'h0001);

        tick();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule